// File: doc/BRIEF.md
# Register-Bank APB Target with Per-Range Read Latency

This block is an APB target that holds a small bank of word registers. The bank is split into equal address ranges. Each range has its own read latency, set by a constant parameter, so one target can answer as a register that replies at once or as a data source that holds off the manager for a few cycles. Accesses that hit no range end at once with the error flag raised, so the bus never stalls on them. Writes to mapped words store the data at once. Writes to unmapped words are dropped, and neither kind waits or errors.

Test benches and bus fabrics use the block as a target with known timing. Its data output reads zero on every cycle except the one where a read completes. A manager that samples read data before `pready` is high therefore captures zero, and the fault shows up plainly in a waveform.

Top module: `apb_rs_target`

## Requirements
- R1: After `presetn` is released, every mapped word reads zero, and while reset is low `pready` is 1, `pslverr` is 0 and `prdata` is 0.
- R2: A read of a word in range 0 (default 0 waits) completes in its first access cycle and returns the last value written to that word.
- R3: A read of a mapped word in range r sees exactly RANGE_WAITS[r] access cycles with `pready` low, then completes on the next access cycle with the stored value. By default the word index is `paddr[5:2]`, range r covers word indices 4r to 4r+3, and the waits are 0, 2 and 5 for ranges 0, 1 and 2.
- R4: `prdata` is 0 in every cycle that is not a read completion, including setup cycles and wait cycles.
- R5: A read of an unmapped address completes in its first access cycle with `pslverr` 1 and `prdata` 0. Unmapped means a word index of 12 or more, or `paddr[1:0]` not zero.
- R6: `pslverr` is 0 in every cycle other than the completion cycle of a read from an unmapped address.
- R7: A write completes in its first access cycle with `pslverr` 0. A write to a mapped word stores `pwdata`. A write to an unmapped address changes no mapped word.
- R8: `pready` is 1 whenever the bus is not in an access cycle.
- R9: If a read is dropped (`psel` goes low) during its wait cycles, the next read is charged its full wait count again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Target select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, non-zero only at read completion |
| pready | output | 1 | Transfer completes when high in an access cycle |
| pslverr | output | 1 | Error flag for unmapped reads |

## Verification
A wait counter loaded from the wrong range, or not reloaded after a dropped transfer, shows up in the very transfer it belongs to: the count of `pready`-low access cycles differs from the range setting, so the bench counts the waits on every read. A bad address decode shows up at the completion edge of the same transfer as a wrong `pslverr` or wrong data. A register corrupted by a write, or by a dropped write, stays hidden until that word is read back, so every word is read back after each write sweep.

// File: rtl/apb_rs_pkg.sv
package apb_rs_pkg;

   // Bus phase as seen by the target on the current cycle
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_ACCESS = 2'd2
   } apb_phase_e;

   // Width of a word index able to address N words (at least one bit)
   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/apb_rs_decode.sv
module apb_rs_decode #(
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned WAIT_W      = 4,
   parameter int unsigned NUM_RANGES  = 3,
   parameter int unsigned RANGE_WORDS = 4,
   parameter logic [NUM_RANGES*WAIT_W-1:0] RANGE_WAITS = '0,
   localparam int unsigned MAP_WORDS  = NUM_RANGES * RANGE_WORDS,
   localparam int unsigned IDX_W      = apb_rs_pkg::idx_width(MAP_WORDS)
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [IDX_W-1:0]  word_idx,
   output logic [WAIT_W-1:0] wait_cnt
);

   logic [31:0]       word_addr;
   logic [NUM_RANGES-1:0] range_hit;
   logic [WAIT_W-1:0] range_wait [NUM_RANGES];
   logic              aligned;

   assign word_addr = 32'(addr[ADDR_W-1:2]);
   assign aligned   = (addr[1:0] == 2'b00);

   for (genvar r = 0; r < NUM_RANGES; r++) begin : g_range
      localparam int unsigned LO = r * RANGE_WORDS;
      localparam int unsigned HI = LO + RANGE_WORDS;
      assign range_hit[r]  = (word_addr >= LO) && (word_addr < HI);
      assign range_wait[r] = RANGE_WAITS[r*WAIT_W +: WAIT_W];
   end

   always_comb begin
      wait_cnt = '0;
      for (int r = 0; r < NUM_RANGES; r++) begin
         if (range_hit[r]) wait_cnt = wait_cnt | range_wait[r];
      end
   end

   assign hit      = aligned && (|range_hit);
   assign word_idx = addr[IDX_W+1:2];

endmodule

// File: rtl/apb_rs_pacer.sv
module apb_rs_pacer #(
   parameter int unsigned WAIT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              access,
   input  logic [WAIT_W-1:0] load_val,
   output logic              ready
);

   logic              busy_q;
   logic [WAIT_W-1:0] cnt_q;
   logic [WAIT_W-1:0] remaining;

   // First access cycle takes the range setting, later ones the running count
   assign remaining = busy_q ? cnt_q : load_val;
   assign ready     = !access || (remaining == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (access && !ready) begin
         busy_q <= 1'b1;
         cnt_q  <= remaining - 1'b1;
      end else begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end
   end

endmodule

// File: rtl/apb_rs_bank.sv
module apb_rs_bank #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned WORDS     = 12,
   parameter logic [DATA_W-1:0] RESET_VAL = '0,
   localparam int unsigned IDX_W    = apb_rs_pkg::idx_width(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ridx,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] word_q [WORDS];

   for (genvar i = 0; i < WORDS; i++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             word_q[i] <= RESET_VAL;
         else if (we && (widx == IDX_W'(i)))     word_q[i] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < WORDS; i++) begin
         if (ridx == IDX_W'(i)) rdata = word_q[i];
      end
   end

endmodule

// File: rtl/apb_rs_target.sv
module apb_rs_target #(
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned WAIT_W      = 4,
   parameter int unsigned NUM_RANGES  = 3,
   parameter int unsigned RANGE_WORDS = 4,
   parameter logic [NUM_RANGES*WAIT_W-1:0] RANGE_WAITS = {4'd5, 4'd2, 4'd0}
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   output logic              pready,
   output logic              pslverr
);
   import apb_rs_pkg::*;

   localparam int unsigned MAP_WORDS = NUM_RANGES * RANGE_WORDS;
   localparam int unsigned IDX_W     = idx_width(MAP_WORDS);
   localparam int unsigned WA_W      = ADDR_W - 2;

   // Elaboration-time parameter checks
   if (DATA_W % 8 != 0) begin : g_bad_data_w
      $error("DATA_W must be a whole number of bytes");
   end
   if (ADDR_W < 3 || IDX_W + 2 > ADDR_W) begin : g_bad_addr_w
      $error("ADDR_W too small for the mapped words");
   end
   if (NUM_RANGES == 0 || RANGE_WORDS == 0) begin : g_bad_map
      $error("at least one range of at least one word is required");
   end
   if (MAP_WORDS > (1 << WA_W)) begin : g_bad_span
      $error("mapped words exceed the address space");
   end

   apb_phase_e        phase;
   logic              access;
   logic              done;
   logic              hit;
   logic [IDX_W-1:0]  word_idx;
   logic [WAIT_W-1:0] range_wait;
   logic [WAIT_W-1:0] load_val;
   logic [DATA_W-1:0] bank_rdata;
   logic              bank_we;

   always_comb begin
      if (!psel)        phase = PH_IDLE;
      else if (penable) phase = PH_ACCESS;
      else              phase = PH_SETUP;
   end

   assign access = (phase == PH_ACCESS);

   apb_rs_decode #(
      .ADDR_W      (ADDR_W),
      .WAIT_W      (WAIT_W),
      .NUM_RANGES  (NUM_RANGES),
      .RANGE_WORDS (RANGE_WORDS),
      .RANGE_WAITS (RANGE_WAITS)
   ) u_decode (
      .addr     (paddr),
      .hit      (hit),
      .word_idx (word_idx),
      .wait_cnt (range_wait)
   );

   // Only mapped reads are slowed; writes and unmapped accesses finish at once
   assign load_val = (pwrite || !hit) ? '0 : range_wait;

   apb_rs_pacer #(
      .WAIT_W (WAIT_W)
   ) u_pacer (
      .clk      (pclk),
      .rst_n    (presetn),
      .access   (access),
      .load_val (load_val),
      .ready    (pready)
   );

   assign done    = access && pready;
   assign bank_we = done && pwrite && hit;

   apb_rs_bank #(
      .DATA_W (DATA_W),
      .WORDS  (MAP_WORDS)
   ) u_bank (
      .clk   (pclk),
      .rst_n (presetn),
      .we    (bank_we),
      .widx  (word_idx),
      .wdata (pwdata),
      .ridx  (word_idx),
      .rdata (bank_rdata)
   );

   assign prdata  = (done && !pwrite && hit) ? bank_rdata : '0;
   assign pslverr = done && !pwrite && !hit;

endmodule

// File: rtl/apb_rs_target_chk.sv
module apb_rs_target_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned WAIT_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              psel,
   input logic              penable,
   input logic              pwrite,
   input logic [DATA_W-1:0] prdata,
   input logic              pready,
   input logic              pslverr
);

   localparam int unsigned WAIT_LIMIT = (1 << WAIT_W) - 1;

   logic [WAIT_W:0] stall_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           stall_run <= '0;
      else if (psel && penable && !pready)  stall_run <= stall_run + 1'b1;
      else                                  stall_run <= '0;
   end

   // R8
   idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(psel && penable) |-> pready);

   // R6
   err_at_read_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pslverr |-> (psel && penable && pready && !pwrite));

   // R4
   rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(psel && penable && pready) |-> (prdata == '0));

   // R5
   err_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pslverr |-> (prdata == '0));

   // R7
   write_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && penable && pwrite) |-> (pready && !pslverr));

   // R3
   stall_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall_run <= WAIT_LIMIT);

endmodule

bind apb_rs_target apb_rs_target_chk #(
   .DATA_W (DATA_W),
   .WAIT_W (WAIT_W)
) u_chk (
   .clk     (pclk),
   .rst_n   (presetn),
   .psel    (psel),
   .penable (penable),
   .pwrite  (pwrite),
   .prdata  (prdata),
   .pready  (pready),
   .pslverr (pslverr)
);

// File: tb/apb_rs_target_test.sv
module apb_rs_target_test;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 6;
   localparam int DATA_W = 32;
   localparam int WORDS  = 16;
   localparam int MAPPED = 12;

   logic              pclk = 1'b0;
   logic              presetn = 1'b0;
   logic              psel = 1'b0;
   logic              penable = 1'b0;
   logic              pwrite = 1'b0;
   logic [ADDR_W-1:0] paddr = '0;
   logic [DATA_W-1:0] pwdata = '0;
   logic [DATA_W-1:0] prdata;
   logic              pready;
   logic              pslverr;

   int checks = 0;
   int fails  = 0;
   bit done_flag = 1'b0;
   logic [DATA_W-1:0] model [MAPPED];

   always #(CLK_PERIOD/2) pclk = ~pclk;

   apb_rs_target uut (
      .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
      .prdata(prdata), .pready(pready), .pslverr(pslverr)
   );

   function automatic int exp_waits(input int idx);
      if (idx >= MAPPED) return 0;
      case (idx / 4)
         0: return 0;
         1: return 2;
         default: return 5;
      endcase
   endfunction

   function automatic logic [DATA_W-1:0] pat(input int idx, input int round);
      return 32'h9E37_0000 + 32'(idx) * 32'h0001_0203 + 32'(round) * 32'h0100_0011;
   endfunction

   task automatic chk(input string tag, input logic [DATA_W-1:0] act,
                      input logic [DATA_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle();
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic apb_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] data,
                           output int waits, output logic err);
      @(negedge pclk);
      psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
      #1;
      chk("R8 setup ready", 32'(pready), 32'd1);
      chk("R4 setup data zero", prdata, '0);
      @(negedge pclk);
      penable = 1'b1;
      waits = 0;
      for (int k = 0; k < 40; k++) begin
         #1;
         if (pready) break;
         waits++;
         chk("R4 wait data zero", prdata, '0);
         chk("R6 wait no error", 32'(pslverr), 32'd0);
         @(negedge pclk);
      end
      data = prdata;
      err  = pslverr;
   endtask

   task automatic apb_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      @(negedge pclk);
      psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
      @(negedge pclk);
      penable = 1'b1;
      #1;
      chk("R7 write first-cycle ready", 32'(pready), 32'd1);
      chk("R6 write no error", 32'(pslverr), 32'd0);
   endtask

   task automatic read_check(input int idx, input logic [1:0] low, input string tag);
      logic [DATA_W-1:0] d;
      int w;
      logic e;
      bit bad;
      bad = (idx >= MAPPED) || (low != 2'b00);
      apb_read(ADDR_W'({idx[3:0], low}), d, w, e);
      if (bad) begin
         chk({tag, " R5 error flag"}, 32'(e), 32'd1);
         chk({tag, " R5 error data zero"}, d, '0);
         chk({tag, " R5 error no waits"}, 32'(w), 32'd0);
      end else begin
         chk({tag, " R6 no error"}, 32'(e), 32'd0);
         chk({tag, (idx < 4) ? " R2 data" : " R3 data"}, d, model[idx]);
         chk({tag, (idx < 4) ? " R2 waits" : " R3 waits"}, 32'(w), 32'(exp_waits(idx)));
      end
   endtask

   initial begin
      repeat (50000) @(posedge pclk);
      if (!done_flag) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < MAPPED; i++) model[i] = '0;
      #(CLK_PERIOD * 2 + 1);
      chk("R1 reset ready", 32'(pready), 32'd1);
      chk("R1 reset no error", 32'(pslverr), 32'd0);
      chk("R1 reset data", prdata, '0);
      @(negedge pclk);
      presetn = 1'b1;

      // R1: every word after reset, with idle between reads
      for (int i = 0; i < WORDS; i++) begin
         read_check(i, 2'b00, $sformatf("R1 word %0d", i));
         idle();
      end

      // R7: fill every address, unmapped writes must be dropped
      for (int round = 1; round <= 2; round++) begin
         for (int i = 0; i < WORDS; i++) begin
            apb_write(ADDR_W'({i[3:0], 2'b00}), pat(i, round));
            if (i < MAPPED) model[i] = pat(i, round);
         end
         idle();
         // R2 R3 R5: back-to-back reads without idle cycles
         for (int i = WORDS - 1; i >= 0; i--)
            read_check(i, 2'b00, $sformatf("round %0d word %0d", round, i));
         idle();
      end

      // R5: misaligned addresses inside mapped ranges
      read_check(5, 2'b01, "misaligned w5");
      read_check(9, 2'b10, "misaligned w9");
      read_check(0, 2'b11, "misaligned w0");
      idle();

      // R7: misaligned write is dropped, all mapped words unchanged
      apb_write(ADDR_W'({4'd6, 2'b01}), 32'hDEAD_BEEF);
      idle();
      for (int i = 0; i < MAPPED; i++)
         read_check(i, 2'b00, $sformatf("R7 after dropped write word %0d", i));
      idle();

      // R9: drop a slow read after two waits, then reread the range
      @(negedge pclk);
      psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = ADDR_W'({4'd8, 2'b00});
      @(negedge pclk);
      penable = 1'b1;
      #1 chk("R9 dropped read wait 1", 32'(pready), 32'd0);
      @(negedge pclk);
      #1 chk("R9 dropped read wait 2", 32'(pready), 32'd0);
      idle();
      #1 chk("R8 ready after drop", 32'(pready), 32'd1);
      read_check(9, 2'b00, "R9 reread after drop");
      idle();

      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule